// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block is the master side of an external memory bus on which the address and the data share the same lines. An internal requester hands it one access at a time through a ready/valid handshake. Each access carries a direction, a byte address, write data, per-byte enables and the index of the chip select to use. The controller then runs one complete bus cycle and returns to idle. A read ends with the captured data and a one-clock done pulse. A write ends with the done pulse only.

The block runs on a clock at twice the external bus rate, so one clock tick is one half-period of the bus clock. A cycle has an address part and a data part. Their lengths come from two configuration inputs, each giving a phase count from 1 to 4, and the controller samples both at the moment it accepts a request. The address part lasts 2a ticks and the data part lasts 2b ticks. A write adds one more tick at the end, in which the shared lines carry the address again. The shared lines are modelled as an output value, an output-enable and an input value, so a pad ring above the block can build the tri-state pins. The upper address bits leave on lines of their own.

In what follows, tick 0 is the first clock cycle after the edge that accepts the request. a and b are the effective phase counts after clamping.

Top module: `mux_bus_ctrl`

## Requirements
- R1: `req_ready` is high exactly when no cycle is in progress, and a request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` raised while a cycle is running starts nothing: after that cycle's done pulse the bus is idle and `req_ready` is high.
- R2: The phase counts are sampled from `cfg_addr_ph` and `cfg_data_ph` when the request is accepted. A value of 0 is used as 1, and a value above 4 is used as 4. Changing these inputs during a cycle does not alter that cycle.
- R3: `ale` is high in ticks 0 to a-1 and low otherwise. In ticks 0 to 2a-1, `ad_oe` is high and `ad_out` equals the low DW bits of the request address.
- R4: On a read, `rd_n` is low in ticks 2a to 2a+2b-2 (2b-1 ticks) and high otherwise. From tick 2a onwards `ad_oe` is low, and `wr_n` stays high.
- R5: On a read, `ad_in` is captured at the clock edge that ends tick 2a+2b-2. The captured value is presented on `rsp_rdata` in the cycle where `rsp_done` is high.
- R6: On a write, `wr_n` is low in ticks 2a to 2a+2b-2 and `rd_n` stays high. `ad_out` equals the write data with `ad_oe` high in ticks 2a to 2a+2b-1, so the data outlasts the strobe by one tick.
- R7: Bit i of `wr_lane_n` (bit 0 is the low byte, bit 1 the high byte) is low only while `wr_n` is low and byte enable i of a write is set. On reads it stays high.
- R8: Only the selected `cs_n` bit is low, and only in ticks 0 to 2a+2b-1. In those ticks `addr_hi` equals the upper address bits and `bhe_n` is low exactly when the top byte enable is set. At all other times `bhe_n` is high.
- R9: On a write, in tick 2a+2b every `cs_n` bit is high and `ad_out` carries the low address bits again with `ad_oe` high.
- R10: `rsp_done` is high for one cycle, the cycle after the last tick. The last tick is 2a+2b-1 for a read and 2a+2b for a write. In that cycle `ale` is low, all strobes and chip selects are high and `ad_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate; one tick per half bus period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_ph | input | 3 | Address-part phase count a (clamped to 1..4) |
| cfg_data_ph | input | 3 | Data-part phase count b (clamped to 1..4) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (24) | Byte address |
| req_wdata | input | DW (16) | Write data |
| req_be | input | DW/8 (2) | Byte enables, bit 1 = high byte |
| req_cs | input | 2 | Index of the chip select to use |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW (16) | Captured read data |
| ale | output | 1 | Address latch enable, active high |
| cs_n | output | NCS (4) | Chip selects, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Combined write strobe, active low |
| wr_lane_n | output | DW/8 (2) | Per-byte write strobes, active low |
| bhe_n | output | 1 | Byte-high enable, active low |
| addr_hi | output | AW-DW (8) | Upper address bits on dedicated lines |
| ad_out | output | DW (16) | Value driven on the shared lines |
| ad_oe | output | 1 | Output-enable for the shared lines |
| ad_in | input | DW (16) | Value seen on the shared lines |

## Verification
Reads and writes are mixed over random phase counts, addresses, byte enables and chip selects. The bench checks every output on every tick, so an error in the address part is told apart from an error in the data part. During reads the bench changes `ad_in` on every tick, and only capture at the correct edge returns the expected word. Directed cases cover the shortest and longest cycles, the clamped values 0 and 7, and writes with no byte enable or with a single one. A stray `req_valid` and a configuration change in the middle of a cycle show that both are ignored.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  // Largest phase count per cycle part.
  localparam int PH_MAX = 4;
  localparam int PH_W   = 3;
  // Longest write: 2*PH_MAX + 2*PH_MAX + 1 ticks, plus margin.
  localparam int TICK_W = $clog2(4 * PH_MAX + 2);

  typedef logic [PH_W-1:0]   phase_t;
  typedef logic [TICK_W-1:0] tick_t;

  // Bring a configured phase count into 1..PH_MAX.
  function automatic phase_t ph_clamp(phase_t p);
    if (p == '0)
      return phase_t'(1);
    if (p > phase_t'(PH_MAX))
      return phase_t'(PH_MAX);
    return p;
  endfunction

  function automatic tick_t ph_ticks(phase_t p);
    return tick_t'({p, 1'b0});
  endfunction

  // First tick of the data part.
  function automatic tick_t data_start(phase_t a);
    return ph_ticks(a);
  endfunction

  // Last tick with a strobe active.
  function automatic tick_t strobe_last(phase_t a, phase_t b);
    return tick_t'(ph_ticks(a) + ph_ticks(b) - tick_t'(2));
  endfunction

  // First tick after the chip-select window.
  function automatic tick_t cs_end(phase_t a, phase_t b);
    return tick_t'(ph_ticks(a) + ph_ticks(b));
  endfunction

  // Final tick of the cycle; writes carry one extra address tick.
  function automatic tick_t cycle_last(phase_t a, phase_t b, logic wr);
    return wr ? cs_end(a, b) : tick_t'(cs_end(a, b) - tick_t'(1));
  endfunction

endpackage

// File: rtl/mbc_req_latch.sv
module mbc_req_latch
  import mux_bus_pkg::*;
#(
  parameter int AW   = 24,
  parameter int DW   = 16,
  parameter int NCS  = 4,
  localparam int LANES = DW / 8,
  localparam int CSW   = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  phase_t           cfg_a,
  input  phase_t           cfg_b,
  input  logic             in_write,
  input  logic [AW-1:0]    in_addr,
  input  logic [DW-1:0]    in_wdata,
  input  logic [LANES-1:0] in_be,
  input  logic [CSW-1:0]   in_cs,
  output phase_t           lat_a,
  output phase_t           lat_b,
  output logic             lat_write,
  output logic [AW-1:0]    lat_addr,
  output logic [DW-1:0]    lat_wdata,
  output logic [LANES-1:0] lat_be,
  output logic [CSW-1:0]   lat_cs
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a     <= phase_t'(1);
      lat_b     <= phase_t'(1);
      lat_write <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_be    <= '0;
      lat_cs    <= '0;
    end else if (take) begin
      lat_a     <= ph_clamp(cfg_a);
      lat_b     <= ph_clamp(cfg_b);
      lat_write <= in_write;
      lat_addr  <= in_addr;
      lat_wdata <= in_wdata;
      lat_be    <= in_be;
      lat_cs    <= in_cs;
    end
  end

endmodule

// File: rtl/mbc_phase_timer.sv
module mbc_phase_timer
  import mux_bus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  phase_t ph_a,
  input  phase_t ph_b,
  input  logic   is_wr,
  output logic   busy,
  output tick_t  tick,
  output logic   ale_win,
  output logic   addr_win,
  output logic   strobe_win,
  output logic   cs_win,
  output logic   data_win,
  output logic   tail_win,
  output logic   evt_sample,
  output logic   evt_last,
  output logic   done
);

  tick_t t_data, t_strobe, t_cs, t_last;

  always_comb begin
    t_data   = data_start(ph_a);
    t_strobe = strobe_last(ph_a, ph_b);
    t_cs     = cs_end(ph_a, ph_b);
    t_last   = cycle_last(ph_a, ph_b, is_wr);
  end

  always_comb begin
    ale_win    = busy && (tick < tick_t'(ph_a));
    addr_win   = busy && (tick < t_data);
    strobe_win = busy && (tick >= t_data) && (tick <= t_strobe);
    data_win   = busy && (tick >= t_data) && (tick < t_cs);
    cs_win     = busy && (tick < t_cs);
    tail_win   = busy && is_wr && (tick == t_cs);
    evt_sample = busy && (tick == t_strobe);
    evt_last   = busy && (tick == t_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tick <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        tick <= '0;
      end else if (busy) begin
        if (evt_last) begin
          busy <= 1'b0;
          tick <= '0;
          done <= 1'b1;
        end else begin
          tick <= tick + tick_t'(1);
        end
      end
    end
  end

endmodule

// File: rtl/mbc_strobe_decode.sv
module mbc_strobe_decode #(
  parameter int LANES = 2,
  parameter int NCS   = 4,
  localparam int CSW  = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic             busy,
  input  logic             is_wr,
  input  logic             strobe_win,
  input  logic             cs_win,
  input  logic [LANES-1:0] be,
  input  logic [CSW-1:0]   cs_sel,
  output logic             rd_n,
  output logic             wr_n,
  output logic [LANES-1:0] wr_lane_n,
  output logic [NCS-1:0]   cs_n,
  output logic             bhe_n
);

  always_comb begin
    rd_n  = !(strobe_win && !is_wr);
    wr_n  = !(strobe_win && is_wr);
    bhe_n = !(busy && cs_win && be[LANES-1]);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_lane_n[g] = !(strobe_win && is_wr && be[g]);
  end

  for (genvar c = 0; c < NCS; c++) begin : g_cs
    assign cs_n[c] = !(cs_win && (cs_sel == CSW'(c)));
  end

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mux_bus_pkg::*;
#(
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int NCS = 4,
  localparam int LANES = DW / 8,
  localparam int CSW   = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int HW    = AW - DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  cfg_addr_ph,
  input  logic [PH_W-1:0]  cfg_data_ph,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_be,
  input  logic [CSW-1:0]   req_cs,
  output logic             rsp_done,
  output logic [DW-1:0]    rsp_rdata,
  output logic             ale,
  output logic [NCS-1:0]   cs_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic [LANES-1:0] wr_lane_n,
  output logic             bhe_n,
  output logic [HW-1:0]    addr_hi,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in
);

  // Named internal events; the bound checker observes these.
  logic             busy, start;
  phase_t           lat_a, lat_b;
  logic             lat_write;
  logic [AW-1:0]    lat_addr;
  logic [DW-1:0]    lat_wdata;
  logic [LANES-1:0] lat_be;
  logic [CSW-1:0]   lat_cs;
  tick_t            tick;
  logic             ale_win, addr_win, strobe_win, cs_win, data_win, tail_win;
  logic             evt_sample, evt_last, evt_rd_sample;
  logic [DW-1:0]    rdata_q;

  assign req_ready     = !busy;
  assign start         = req_valid && req_ready;
  assign evt_rd_sample = evt_sample && !lat_write;

  mbc_req_latch #(.AW(AW), .DW(DW), .NCS(NCS)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (start),
    .cfg_a     (cfg_addr_ph),
    .cfg_b     (cfg_data_ph),
    .in_write  (req_write),
    .in_addr   (req_addr),
    .in_wdata  (req_wdata),
    .in_be     (req_be),
    .in_cs     (req_cs),
    .lat_a     (lat_a),
    .lat_b     (lat_b),
    .lat_write (lat_write),
    .lat_addr  (lat_addr),
    .lat_wdata (lat_wdata),
    .lat_be    (lat_be),
    .lat_cs    (lat_cs)
  );

  mbc_phase_timer u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ph_a       (lat_a),
    .ph_b       (lat_b),
    .is_wr      (lat_write),
    .busy       (busy),
    .tick       (tick),
    .ale_win    (ale_win),
    .addr_win   (addr_win),
    .strobe_win (strobe_win),
    .cs_win     (cs_win),
    .data_win   (data_win),
    .tail_win   (tail_win),
    .evt_sample (evt_sample),
    .evt_last   (evt_last),
    .done       (rsp_done)
  );

  mbc_strobe_decode #(.LANES(LANES), .NCS(NCS)) u_strobe (
    .busy       (busy),
    .is_wr      (lat_write),
    .strobe_win (strobe_win),
    .cs_win     (cs_win),
    .be         (lat_be),
    .cs_sel     (lat_cs),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .wr_lane_n  (wr_lane_n),
    .cs_n       (cs_n),
    .bhe_n      (bhe_n)
  );

  // Shared lines: address first, then write data or release for read data.
  always_comb begin
    ale     = ale_win;
    ad_oe   = addr_win || (lat_write && (data_win || tail_win));
    ad_out  = (lat_write && data_win) ? lat_wdata : lat_addr[DW-1:0];
    addr_hi = lat_addr[AW-1:DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (evt_rd_sample)
      rdata_q <= ad_in;
  end

  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/mux_bus_ctrl_chk.sv
module mux_bus_ctrl_chk #(
  parameter int NCS   = 4,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_done,
  input logic             ale,
  input logic [NCS-1:0]   cs_n,
  input logic             rd_n,
  input logic             wr_n,
  input logic [LANES-1:0] wr_lane_n,
  input logic             ad_oe,
  input logic             evt_rd_sample,
  input logic             evt_last
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ale && rd_n && wr_n && (&cs_n) && !ad_oe)); // R10

  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R8

  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R6

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |-> !(&cs_n)); // R8

  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe); // R6

  AST_LANE_IN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !(&wr_lane_n) |-> !wr_n); // R7

  AST_ALE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && !(&cs_n))); // R3

  AST_SAMPLE_IN_RD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_sample |-> !rd_n); // R5

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_last |=> rsp_done); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R10

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !evt_last) |=> !req_ready); // R1

endmodule

bind mux_bus_ctrl mux_bus_ctrl_chk #(.NCS(NCS), .LANES(LANES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_done      (rsp_done),
  .ale           (ale),
  .cs_n          (cs_n),
  .rd_n          (rd_n),
  .wr_n          (wr_n),
  .wr_lane_n     (wr_lane_n),
  .ad_oe         (ad_oe),
  .evt_rd_sample (evt_rd_sample),
  .evt_last      (evt_last)
);

// File: tb/mux_bus_ctrl_tb.sv
module mux_bus_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int NCS = 4;
  localparam int LN = DW / 8;
  localparam int HW = AW - DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_addr_ph = 3'd2, cfg_data_ph = 3'd2;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [LN-1:0] req_be = '0;
  logic [1:0] req_cs = '0;
  logic [DW-1:0] ad_in = '0;
  logic req_ready, rsp_done, ale, rd_n, wr_n, bhe_n, ad_oe;
  logic [DW-1:0] rsp_rdata, ad_out;
  logic [NCS-1:0] cs_n;
  logic [LN-1:0] wr_lane_n;
  logic [HW-1:0] addr_hi;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_ctrl #(.AW(AW), .DW(DW), .NCS(NCS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr_ph(cfg_addr_ph), .cfg_data_ph(cfg_data_ph),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_cs(req_cs),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ale(ale), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .wr_lane_n(wr_lane_n), .bhe_n(bhe_n),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff_ph(input logic [2:0] p);
    if (p == 0) return 1;
    if (p > 4) return 4;
    return int'(p);
  endfunction

  // Value the bench places on the shared lines during tick k.
  function automatic logic [DW-1:0] line_val(input int k, input logic [DW-1:0] salt);
    return DW'(k * 16'h1357 + 16'h00A5) ^ salt;
  endfunction

  task automatic run_cycle(input logic wr, input logic [2:0] ca, input logic [2:0] cb,
                           input logic [AW-1:0] adr, input logic [DW-1:0] wd,
                           input logic [LN-1:0] be, input logic [1:0] cs, input bit disturb);
    int a = eff_ph(ca);
    int b = eff_ph(cb);
    int t_dat = 2 * a;
    int t_str = 2 * a + 2 * b - 2;
    int t_cse = 2 * a + 2 * b;
    int t_lst = wr ? t_cse : t_cse - 1;
    logic [DW-1:0] salt = DW'($urandom);
    logic [DW-1:0] exp_rd = line_val(t_str, salt);
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready before request", 32'(req_ready), 1);
    cfg_addr_ph = ca; cfg_data_ph = cb;
    req_write = wr; req_addr = adr; req_wdata = wd; req_be = be; req_cs = cs;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k <= t_lst + 1; k++) begin
      if (k <= t_lst) begin
        bit strb = (k >= t_dat) && (k <= t_str);
        logic [NCS-1:0] ecs = (k < t_cse) ? ~(NCS'(1) << cs) : '1;
        logic eoe = (k < t_dat) || wr;
        logic [DW-1:0] ead = (k < t_dat || k == t_cse) ? adr[DW-1:0] : wd;
        chk(ale === (k < a), "R3 ale", 32'(ale), 32'(k < a));
        chk(rd_n === !(strb && !wr), "R4 rd_n", 32'(rd_n), 32'(!(strb && !wr)));
        chk(wr_n === !(strb && wr), "R6 wr_n", 32'(wr_n), 32'(!(strb && wr)));
        chk(wr_lane_n === ((strb && wr) ? ~be : '1), "R7 lane strobes",
            32'(wr_lane_n), 32'((strb && wr) ? ~be : '1));
        chk(cs_n === ecs, (k == t_cse) ? "R9 cs in tail" : "R8 cs_n", 32'(cs_n), 32'(ecs));
        chk(ad_oe === eoe, (k < t_dat) ? "R3 oe" : (wr ? "R6 oe" : "R4 oe"), 32'(ad_oe), 32'(eoe));
        if (eoe)
          chk(ad_out === ead, (k < t_dat) ? "R3 addr on lines" :
              ((k == t_cse) ? "R9 addr again" : "R6 wdata"), 32'(ad_out), 32'(ead));
        if (k < t_cse) begin
          chk(addr_hi === adr[AW-1:DW], "R8 addr_hi", 32'(addr_hi), 32'(adr[AW-1:DW]));
          chk(bhe_n === !be[LN-1], "R8 bhe_n", 32'(bhe_n), 32'(!be[LN-1]));
        end else begin
          chk(bhe_n === 1'b1, "R8 bhe_n tail", 32'(bhe_n), 1);
        end
        chk(rsp_done === 1'b0 && req_ready === 1'b0, "R1 busy no done",
            32'({rsp_done, req_ready}), 0);
      end else begin
        chk(rsp_done === 1'b1, "R10 done", 32'(rsp_done), 1);
        chk(req_ready === 1'b1, "R1 idle after done", 32'(req_ready), 1);
        chk(!ale && rd_n && wr_n && (&cs_n) && !ad_oe && (&wr_lane_n),
            "R10 idle outputs", 32'({ale, rd_n, wr_n, cs_n, ad_oe}), 32'({1'b0, 1'b1, 1'b1, 4'hF, 1'b0}));
        if (!wr)
          chk(rsp_rdata === exp_rd, "R5 read data", 32'(rsp_rdata), 32'(exp_rd));
      end
      ad_in = line_val(k, salt);
      if (disturb && k == 1) begin
        // R1/R2: stray request and configuration change mid-cycle
        req_valid = 1'b1; req_addr = ~adr; req_write = !wr;
        cfg_addr_ph = 3'($urandom_range(0, 7)); cfg_data_ph = 3'($urandom_range(0, 7));
      end
      if (k == 2) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(rsp_done === 1'b0, "R10 done single pulse", 32'(rsp_done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_done === 1'b0, "R1 reset ready", 32'({req_ready, rsp_done}), 2);
    chk(!ale && rd_n && wr_n && (&cs_n) && !ad_oe && bhe_n, "R10 reset idle",
        32'({ale, rd_n, wr_n, cs_n, ad_oe, bhe_n}), 32'({3'b011, 4'hF, 2'b01}));
    rst_n = 1'b1;
    // Directed corners
    run_cycle(1'b0, 3'd2, 3'd2, 24'h12_3456, 16'h0, 2'b11, 2'd0, 1'b0);
    run_cycle(1'b1, 3'd2, 3'd2, 24'hAB_CDEF, 16'hBEEF, 2'b11, 2'd1, 1'b0);
    run_cycle(1'b0, 3'd1, 3'd1, 24'h00_0001, 16'h0, 2'b01, 2'd2, 1'b0);
    run_cycle(1'b1, 3'd4, 3'd4, 24'hFF_FFFE, 16'h1234, 2'b10, 2'd3, 1'b0);
    run_cycle(1'b0, 3'd0, 3'd7, 24'h5A_5A5A, 16'h0, 2'b10, 2'd1, 1'b0);   // R2 clamp
    run_cycle(1'b1, 3'd7, 3'd0, 24'h3C_3C3C, 16'h55AA, 2'b00, 2'd2, 1'b0); // R2 clamp, R7 no lanes
    run_cycle(1'b1, 3'd3, 3'd2, 24'h01_0203, 16'hCAFE, 2'b01, 2'd0, 1'b1); // R1 R2 disturb
    run_cycle(1'b0, 3'd1, 3'd4, 24'h77_8899, 16'h0, 2'b11, 2'd3, 1'b1);
    // Constrained random
    for (int n = 0; n < 60; n++) begin
      run_cycle(1'($urandom), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                AW'($urandom), DW'($urandom), LN'($urandom), 2'($urandom),
                ($urandom_range(0, 3) == 0));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule